// File: doc/BRIEF.md
# Overlapped ADC Conversion Sequencer

This block produces the timing strobes for a single-channel ADC front end that converts one sample at a time. Each sample has two phases. First comes an acquisition window, during which the sample/hold stage tracks the input; its length can be programmed. Then comes a conversion phase that is always 13 cycles long. By default, the acquisition window of the next sample is pipelined over the last seven conversion cycles of the current sample. This shortens the steady-state period to the acquisition width plus six cycles. A single control input turns the overlap off, and each sample then takes the acquisition width plus 13 cycles.

A mock converter stands in for the analog core. It returns a running sample count as the result, together with a result-valid strobe on the end-of-conversion cycle. A run enable starts sampling and keeps it going. When the enable is removed, any sample whose acquisition has already begun is finished, and no further sample is started.

Top module: `adc_ovl_seq`

## Requirements
- R1: While reset is low and on the first cycle after it is released, all strobes are low. The first result produced after reset carries the value 0.
- R2: Suppose the sequencer is idle and run_en is high at a rising edge. The acquisition window opens on the next cycle and lasts A cycles. Conversion then starts, and eoc_pulse rises A+13 cycles after that edge. A is the effective acquisition width defined in R6.
- R3: Every conversion lasts exactly 13 cycles. soc_pulse marks the first conversion cycle, eoc_pulse marks the 13th, and conv_active is high on all 13.
- R4: With no_overlap at 0, the next acquisition window opens on the 7th conversion cycle of the current sample. The two phases then run together for 7 cycles, and successive eoc_pulse events are A+6 cycles apart. This gives 13 cycles at A=7 and 15 cycles at A=9.
- R5: With no_overlap at 1, the next acquisition window opens on the cycle after eoc_pulse, and successive eoc_pulse events are A+13 cycles apart. This gives 20 cycles at A=7.
- R6: acq_width is 6 bits wide. The effective width A equals acq_width, except that any value below 7 is raised to 7.
- R7: acq_width is captured on the first cycle of each acquisition window. no_overlap is sampled only at the point where the next sample may begin, which is the 6th or the 13th conversion cycle. A change on either input during a sample therefore leaves that sample's timing unchanged.
- R8: When run_en is low, no new acquisition window opens. A sample whose window has already opened still runs through to its eoc_pulse, after which both phase strobes stay low.
- R9: eoc_pulse lasts one cycle. result_valid is high in exactly the same cycle, and result_data then holds the number of results produced before it, counted modulo 2^RES_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Start sampling and keep sampling continuously |
| acq_width | input | 6 | Acquisition window length in cycles (values below 7 act as 7) |
| no_overlap | input | 1 | 1 disables the overlap of acquisition with conversion |
| acq_active | output | 1 | Acquisition window is open |
| conv_active | output | 1 | Conversion phase is running |
| soc_pulse | output | 1 | First conversion cycle of a sample |
| eoc_pulse | output | 1 | Last conversion cycle of a sample |
| result_valid | output | 1 | result_data is valid |
| result_data | output | 12 | Mock conversion result (running sample count) |

## Verification
Every output follows from registered state, so each strobe is due a fixed number of cycles after the edge that caused it. The acquisition window opens one cycle after the edge that samples run_en. The first eoc_pulse comes A+13 cycles after that edge. soc_pulse comes 12 cycles before its eoc_pulse. Each later eoc_pulse comes A+6 or A+13 cycles after the previous one, where A is the width captured for the later sample.

The driver works out the absolute cycle of every expected eoc_pulse from these rules before it raises run_en, and pushes each one into a queue. A cycle counter and a monitor sample on the falling clock edge. On every eoc_pulse the monitor pops an item and compares the current cycle and result_data against it, so an early or late result is caught on the exact cycle it appears.

// File: rtl/adc_seq_pkg.sv
// Package: adc_seq_pkg
// Shared timing constants of the overlapped ADC sequencer.
// Assumes the conversion is longer than the overlap, and the overlap is no
// longer than the minimum acquisition window.
package adc_seq_pkg;
    localparam int CONV_CYC   = 13;                    // conversion phase length
    localparam int OVL_CYC    = 7;                     // cycles shared by acq(n) and conv(n-1)
    localparam int MIN_ACQ    = 7;                     // shortest acquisition window
    localparam int CONV_CNT_W = $clog2(CONV_CYC);      // conversion counter width
    localparam int OVL_TAP    = CONV_CYC - OVL_CYC - 1; // conv index at which an overlapped start is decided
endpackage

// File: rtl/adc_acq_timer.sv
// Module: adc_acq_timer
// Counts one acquisition window. The programmed width is clamped to the
// minimum and captured when start is pulsed. done marks the last window cycle.
// Assumes start is only pulsed while the timer is not busy.
module adc_acq_timer
    import adc_seq_pkg::*;
#(
    parameter int ACQ_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ACQ_W-1:0] width,
    output logic             busy,
    output logic             done
);
    localparam logic [ACQ_W-1:0] MIN_W = ACQ_W'(MIN_ACQ);

    logic [ACQ_W-1:0] eff_w;
    logic [ACQ_W-1:0] left_q;

    // Clamp the requested width to the minimum window.
    always_comb eff_w = (width < MIN_W) ? MIN_W : width;

    // Load the captured width on start, then count down to the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            left_q <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            left_q <= eff_w - ACQ_W'(1);
        end else if (busy) begin
            if (left_q == '0) busy <= 1'b0;
            else              left_q <= left_q - ACQ_W'(1);
        end
    end

    // Flag the last cycle of the window.
    always_comb done = busy && (left_q == '0);
endmodule

// File: rtl/adc_conv_timer.sv
// Module: adc_conv_timer
// Runs the fixed-length conversion phase. It flags the first cycle, the last
// cycle, and the cycle at which an overlapped next acquisition is decided.
// Assumes start never arrives while a conversion is still running, except on
// its last cycle.
module adc_conv_timer
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic first,
    output logic last,
    output logic tap
);
    localparam logic [CONV_CNT_W-1:0] LAST_IDX = CONV_CNT_W'(CONV_CYC - 1);
    localparam logic [CONV_CNT_W-1:0] TAP_IDX  = CONV_CNT_W'(OVL_TAP);

    logic [CONV_CNT_W-1:0] idx_q;

    // Advance the conversion index; a new start overrides the end of the previous conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            idx_q <= '0;
        end else if (busy) begin
            if (idx_q == LAST_IDX) begin
                busy  <= 1'b0;
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + CONV_CNT_W'(1);
            end
        end
    end

    // Decode the phase markers from the index.
    always_comb begin
        first = busy && (idx_q == '0);
        last  = busy && (idx_q == LAST_IDX);
        tap   = busy && (idx_q == TAP_IDX);
    end
endmodule

// File: rtl/adc_mock_core.sv
// Module: adc_mock_core
// Stand-in for the analog converter. On each capture it presents the running
// sample count as the result and then increments the count.
// Assumes capture is high for one cycle per sample.
module adc_mock_core #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    output logic             valid,
    output logic [RES_W-1:0] data
);
    logic [RES_W-1:0] count_q;

    // Step the sample counter after each delivered result.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (capture) count_q <= count_q + RES_W'(1);
    end

    // Present the current count as the result during capture.
    always_comb begin
        valid = capture;
        data  = count_q;
    end
endmodule

// File: rtl/adc_ovl_seq.sv
// Module: adc_ovl_seq
// Top of the overlapped ADC conversion sequencer. It decides when each
// acquisition window opens: from idle, at the overlap tap of the running
// conversion, or at the conversion's last cycle. It chains each window into
// its conversion and forwards end-of-conversion to the mock core.
// Assumes acq_width and no_overlap are synchronous to clk.
module adc_ovl_seq
    import adc_seq_pkg::*;
#(
    parameter int ACQ_W = 6,
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [ACQ_W-1:0] acq_width,
    input  logic             no_overlap,
    output logic             acq_active,
    output logic             conv_active,
    output logic             soc_pulse,
    output logic             eoc_pulse,
    output logic             result_valid,
    output logic [RES_W-1:0] result_data
);
    logic acq_busy, acq_done;
    logic conv_busy, conv_first, conv_last, conv_tap;
    logic start_acq;

    // Open a window only when enabled and free: from idle, at the overlap tap, or at conversion end.
    always_comb begin
        start_acq = run_en && !acq_busy &&
                    (!conv_busy || (conv_tap && !no_overlap) || conv_last);
    end

    adc_acq_timer #(
        .ACQ_W (ACQ_W)
    ) u_acq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_acq),
        .width (acq_width),
        .busy  (acq_busy),
        .done  (acq_done)
    );

    adc_conv_timer u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .start (acq_done),
        .busy  (conv_busy),
        .first (conv_first),
        .last  (conv_last),
        .tap   (conv_tap)
    );

    adc_mock_core #(
        .RES_W (RES_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (conv_last),
        .valid   (result_valid),
        .data    (result_data)
    );

    // Drive the phase strobes from the timer state.
    always_comb begin
        acq_active  = acq_busy;
        conv_active = conv_busy;
        soc_pulse   = conv_first;
        eoc_pulse   = conv_last;
    end
endmodule

// File: rtl/adc_ovl_seq_chk.sv
// Module: adc_ovl_seq_chk
// Property checker bound to adc_ovl_seq. It observes only the top-level ports.
module adc_ovl_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic no_overlap,
    input logic acq_active,
    input logic conv_active,
    input logic soc_pulse,
    input logic eoc_pulse,
    input logic result_valid
);
    // R2: conversion starts on the cycle right after a window closes.
    p_soc_after_acq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acq_active) |-> soc_pulse);

    // R3: end of conversion comes 12 cycles after its start.
    p_conv_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_pulse |-> $past(soc_pulse, 12));

    // R4 / R5: an acquisition that opens during a conversion needs overlap mode.
    p_ovl_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(acq_active) && conv_active) |-> !$past(no_overlap));

    // R6: no window is shorter than 7 cycles.
    p_acq_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acq_active) |-> $past(acq_active, 7));

    // R8: a window opens only if run_en was high at the deciding edge.
    p_start_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acq_active) |-> $past(run_en));

    // R9: end of conversion lasts a single cycle.
    p_eoc_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_pulse |=> !eoc_pulse);

    // R9: a result appears only on the final conversion cycle.
    p_valid_eoc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (eoc_pulse && conv_active));
endmodule

bind adc_ovl_seq adc_ovl_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .no_overlap   (no_overlap),
    .acq_active   (acq_active),
    .conv_active  (conv_active),
    .soc_pulse    (soc_pulse),
    .eoc_pulse    (eoc_pulse),
    .result_valid (result_valid)
);

// File: tb/adc_ovl_seq_tb.sv
// Scoreboard bench for adc_ovl_seq. The driver computes the absolute cycle and
// data of each expected end-of-conversion; a falling-edge monitor checks them.
module adc_ovl_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RES_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_en = 1'b0;
    logic [5:0]       acq_width = 6'd7;
    logic             no_overlap = 1'b0;
    logic             acq_active, conv_active, soc_pulse, eoc_pulse, result_valid;
    logic [RES_W-1:0] result_data;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    int    next_data = 0;
    bit    mon_on = 1'b0;
    bit    all_done = 1'b0;
    int    q_cyc[$];
    int    q_dat[$];
    string q_tag[$];
    int    w_a[8];
    bit    m_a[8];
    string t_a[8];
    int    last_soc = 0;
    int    conv_run = 0;
    bit    prev_eoc = 1'b0;

    adc_ovl_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .acq_width    (acq_width),
        .no_overlap   (no_overlap),
        .acq_active   (acq_active),
        .conv_active  (conv_active),
        .soc_pulse    (soc_pulse),
        .eoc_pulse    (eoc_pulse),
        .result_valid (result_valid),
        .result_data  (result_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    function automatic int eff(input int w);
        return (w < 7) ? 7 : w;
    endfunction

    task automatic set_s(input int i, input int w, input bit m, input string t);
        w_a[i] = w;
        m_a[i] = m;
        t_a[i] = t;
    endtask

    // Driver: predicts each sample's end-of-conversion, then steps the inputs sample by sample.
    task automatic run_seq(input int n);
        int st[9];
        int e;
        int guard;
        st[0] = cyc + 1;
        for (int k = 0; k < n; k++) begin
            e = st[k] + eff(w_a[k]) + 12;
            q_cyc.push_back(e);
            q_dat.push_back(next_data % (1 << RES_W));
            q_tag.push_back(t_a[k]);
            next_data++;
            st[k+1] = (k + 1 < n && m_a[k+1]) ? e + 1 : e - 6;
        end
        acq_width  = 6'(w_a[0]);
        no_overlap = m_a[0];
        run_en     = 1'b1;
        for (int k = 0; k < n; k++) begin
            while (cyc < st[k]) @(negedge clk);
            chk(acq_active == 1'b1, "R2 window open", int'(acq_active), 1);
            if (k > 0 && !m_a[k])
                chk(conv_active == 1'b1, "R4 overlap with previous conversion", int'(conv_active), 1);
            if (k > 0 && m_a[k])
                chk(conv_active == 1'b0, "R5 no overlap", int'(conv_active), 0);
            // R7: the next sample's settings change while this window is open.
            if (k + 1 < n) begin
                acq_width  = 6'(w_a[k+1]);
                no_overlap = m_a[k+1];
            end else begin
                run_en = 1'b0;
            end
        end
        guard = 0;
        while (q_cyc.size() != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(q_cyc.size() == 0, "R8 pending samples drained", q_cyc.size(), 0);
        repeat (30) @(negedge clk);
        chk(acq_active == 1'b0 && conv_active == 1'b0, "R8 idle after run_en low",
            int'({acq_active, conv_active}), 0);
    endtask

    // Monitor: checks every produced result against the scoreboard.
    always @(negedge clk) begin
        if (mon_on) begin
            if (soc_pulse) begin
                last_soc = cyc;
                conv_run = 1;
            end else if (conv_active) begin
                conv_run++;
            end
            if (result_valid != eoc_pulse)
                chk(1'b0, "R9 valid with eoc", int'(result_valid), int'(eoc_pulse));
            if (eoc_pulse && prev_eoc)
                chk(1'b0, "R9 single-cycle eoc", 2, 1);
            if (eoc_pulse) begin
                if (q_cyc.size() == 0) begin
                    chk(1'b0, "R8 unexpected sample", cyc, -1);
                end else begin
                    int    ec;
                    int    ed;
                    string et;
                    ec = q_cyc.pop_front();
                    ed = q_dat.pop_front();
                    et = q_tag.pop_front();
                    chk(cyc == ec, et, cyc, ec);
                    chk(int'(result_data) == ed, "R9 result data", int'(result_data), ed);
                    chk(cyc - last_soc == 12, "R3 soc to eoc", cyc - last_soc, 12);
                    chk(conv_run == 13, "R3 conversion length", conv_run, 13);
                end
            end
            prev_eoc = eoc_pulse;
        end
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!all_done) begin
            n_bad++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs low in reset.
        chk({acq_active, conv_active, soc_pulse, eoc_pulse, result_valid} == 5'b0,
            "R1 outputs in reset", int'({acq_active, conv_active, soc_pulse, eoc_pulse, result_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({acq_active, conv_active, soc_pulse, eoc_pulse, result_valid} == 5'b0,
            "R1 outputs after reset", int'({acq_active, conv_active, soc_pulse, eoc_pulse, result_valid}), 0);
        mon_on = 1'b1;

        // R2/R4: minimum window in overlap mode, 13-cycle period.
        set_s(0, 7, 0, "R2 first eoc, A=7");
        set_s(1, 7, 0, "R4 period 13");
        set_s(2, 7, 0, "R4 period 13");
        run_seq(3);

        // R4: 9-cycle window gives 15-cycle period.
        set_s(0, 9, 0, "R2 first eoc, A=9");
        set_s(1, 9, 0, "R4 period 15");
        set_s(2, 9, 0, "R4 period 15");
        run_seq(3);

        // R5: overlap disabled, 20-cycle period.
        set_s(0, 7, 1, "R2 first eoc, no overlap");
        set_s(1, 7, 1, "R5 period 20");
        set_s(2, 7, 1, "R5 period 20");
        run_seq(3);

        // R6: widths below minimum act as 7.
        set_s(0, 3, 0, "R6 clamp width 3");
        set_s(1, 0, 0, "R6 clamp width 0");
        run_seq(2);

        // R7: mixed widths and modes switched at sample boundaries only.
        set_s(0, 9, 0, "R7 first sample A=9");
        set_s(1, 20, 0, "R7 width 20 takes effect next sample");
        set_s(2, 7, 1, "R7 mode change next sample");
        set_s(3, 63, 0, "R7 max width 63");
        run_seq(4);

        // R8: a single sample then stop.
        set_s(0, 12, 0, "R8 single sample");
        run_seq(1);

        all_done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule